// File: doc/BRIEF.md
# Thread Block Warp Partitioner

This block turns a one-dimensional kernel launch into the sequence of warps that a warp scheduler consumes. A launch supplies three values: the number of thread blocks in the grid, the number of threads in each block and the element count N that the kernel guards against. The partitioner splits every block into groups of consecutive threads, one group per warp. For each warp it produces a descriptor that carries the block number, the warp number within the block, the global thread index of lane 0 and a per-lane active mask.

A lane is active only when it is a real thread of its block and its global index is below N. A mask with cleared bits therefore marks a warp that will diverge on the usual `if (index < N)` bounds check. A mask with every bit cleared marks a warp that the scheduler can retire without issuing it.

Descriptors leave one per cycle over a valid/ready handshake, so the scheduler can stall the stream. After the last descriptor is accepted the block raises a one-cycle completion pulse and then accepts the next launch.

Top module: `warp_splitter`

## Requirements
- R1: After reset, `descValid` and `done` are low and `launchReady` is high.
- R2: Each block yields ceil(blockThreads / WARP_LANES) descriptors. With the default WARP_LANES of 32, a 128-thread block yields exactly 4.
- R3: Descriptors are emitted in ascending block order. Within a block they go in ascending warp order, with `descBlock` and `descWarp` holding those two numbers.
- R4: `descBase` equals block × blockThreads + warp × WARP_LANES. This is the global thread index of lane 0, and lane l covers index `descBase` + l.
- R5: Bit l of `descMask` is 1 exactly when warp × WARP_LANES + l < blockThreads and `descBase` + l < elemCount.
- R6: With one block of 64 threads and elemCount 60, warp 0 has all 32 lanes active and warp 1 has only bits 0..27 set.
- R7: While `descValid` is high and `descReady` is low, every descriptor output holds its value until the next cycle.
- R8: A warp whose mask is all zero is still emitted, with `descEmpty` high. `descEmpty` is low for any other mask.
- R9: `done` is high for exactly the one cycle after the handshake of the final descriptor of a launch.
- R10: A launch is taken only on a cycle where `launchValid` and `launchReady` are both high. `launchReady` is low while descriptors are pending, and `launchValid` during that time does not change the stream.
- R11: A launch with zero blocks or zero threads per block emits no descriptor and raises `done` in the cycle after it is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| launchValid | input | 1 | Launch request |
| launchReady | output | 1 | Partitioner is idle and takes a launch |
| gridBlocks | input | BLK_W | Number of blocks in the grid |
| blockThreads | input | TPB_W | Threads per block |
| elemCount | input | IDX_W | Bound N on the global thread index |
| descValid | output | 1 | Descriptor offered |
| descReady | input | 1 | Scheduler accepts the descriptor |
| descBlock | output | BLK_W | Block number |
| descWarp | output | TPB_W | Warp number within the block |
| descBase | output | IDX_W | Global index of lane 0 |
| descMask | output | WARP_LANES | Per-lane active mask |
| descEmpty | output | 1 | Mask is all zero |
| done | output | 1 | One-cycle completion pulse |

## Verification
A block that exactly fills its warps, with N equal to the thread count, shows the warp count and the base arithmetic without any masking. The 64-thread case with N of 60 isolates the bound check inside one warp. A 48-thread block separates the block-size cut from the N cut, and tiny 4-thread blocks with a small N show a base that strides by block size and produce warps whose masks are all zero. Throttled ready patterns, launch requests made while busy and zero-sized launches exercise stalls, launch gating and the path that completes with no descriptors.

// File: rtl/warp_split_pkg.sv
package warp_split_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ws_state_t;

  typedef struct packed {
    logic load;       // latch launch configuration, clear counters
    logic stepWarp;   // advance to next warp in the same block
    logic stepBlock;  // advance to warp 0 of the next block
  } ws_strobe_t;

endpackage

// File: rtl/ws_ctrl.sv
module ws_ctrl
  import warp_split_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       launchValid,
  input  logic       zeroLaunch,
  input  logic       descReady,
  input  logic       lastWarp,
  input  logic       lastBlock,
  output logic       launchReady,
  output logic       descValid,
  output logic       done,
  output ws_strobe_t stb
);

  ws_state_t state, stateNx;
  logic      fire;
  logic      finalFire;
  logic      zeroTaken;
  logic      doneQ;

  assign launchReady = (state == ST_IDLE);
  assign descValid   = (state == ST_RUN);
  assign fire        = descValid && descReady;
  assign finalFire   = fire && lastWarp && lastBlock;
  assign zeroTaken   = launchReady && launchValid && zeroLaunch;
  assign done        = doneQ;

  always_comb begin
    stb     = '0;
    stateNx = state;
    unique case (state)
      ST_IDLE: begin
        if (launchValid && !zeroLaunch) begin
          stb.load = 1'b1;
          stateNx  = ST_RUN;
        end
      end
      ST_RUN: begin
        if (fire) begin
          if (lastWarp) begin
            if (lastBlock) stateNx = ST_IDLE;
            else           stb.stepBlock = 1'b1;
          end else begin
            stb.stepWarp = 1'b1;
          end
        end
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      doneQ <= 1'b0;
    end else begin
      state <= stateNx;
      doneQ <= finalFire || zeroTaken;
    end
  end

endmodule

// File: rtl/ws_datapath.sv
module ws_datapath
  import warp_split_pkg::*;
#(
  parameter int WARP_LANES = 32,
  parameter int IDX_W      = 32,
  parameter int BLK_W      = 16,
  parameter int TPB_W      = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ws_strobe_t            stb,
  input  logic [BLK_W-1:0]      gridBlocks,
  input  logic [TPB_W-1:0]      blockThreads,
  input  logic [IDX_W-1:0]      elemCount,
  output logic [BLK_W-1:0]      descBlock,
  output logic [TPB_W-1:0]      descWarp,
  output logic [IDX_W-1:0]      descBase,
  output logic [WARP_LANES-1:0] descMask,
  output logic                  descEmpty,
  output logic                  lastWarp,
  output logic                  lastBlock
);

  localparam int LANE_W = $clog2(WARP_LANES);
  localparam int CMP_W  = IDX_W + 1;

  logic [BLK_W-1:0] cfgGrid;
  logic [TPB_W-1:0] cfgThreads;
  logic [TPB_W-1:0] cfgWarps;
  logic [IDX_W-1:0] cfgBound;

  logic [BLK_W-1:0] blkIdx;
  logic [TPB_W-1:0] wrpIdx;
  logic [IDX_W-1:0] blkBase;   // running block index * threads per block
  logic [IDX_W-1:0] warpOff;   // running warp index * lanes

  logic [TPB_W:0]   roundUp;
  logic [TPB_W-1:0] warpsNeeded;

  assign roundUp     = {1'b0, blockThreads} + (TPB_W+1)'(WARP_LANES - 1);
  assign warpsNeeded = TPB_W'(roundUp >> LANE_W);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgGrid    <= '0;
      cfgThreads <= '0;
      cfgWarps   <= '0;
      cfgBound   <= '0;
      blkIdx     <= '0;
      wrpIdx     <= '0;
      blkBase    <= '0;
      warpOff    <= '0;
    end else if (stb.load) begin
      cfgGrid    <= gridBlocks;
      cfgThreads <= blockThreads;
      cfgWarps   <= warpsNeeded;
      cfgBound   <= elemCount;
      blkIdx     <= '0;
      wrpIdx     <= '0;
      blkBase    <= '0;
      warpOff    <= '0;
    end else if (stb.stepBlock) begin
      blkIdx     <= blkIdx + 1'b1;
      wrpIdx     <= '0;
      blkBase    <= blkBase + IDX_W'(cfgThreads);
      warpOff    <= '0;
    end else if (stb.stepWarp) begin
      wrpIdx     <= wrpIdx + 1'b1;
      warpOff    <= warpOff + IDX_W'(WARP_LANES);
    end
  end

  assign descBlock = blkIdx;
  assign descWarp  = wrpIdx;
  assign descBase  = blkBase + warpOff;
  assign lastWarp  = (wrpIdx == cfgWarps - 1'b1);
  assign lastBlock = (blkIdx == cfgGrid - 1'b1);

  for (genvar l = 0; l < WARP_LANES; l++) begin : g_lane
    logic [CMP_W-1:0] globalIdx;
    logic [CMP_W-1:0] localIdx;
    assign globalIdx   = {1'b0, descBase} + CMP_W'(l);
    assign localIdx    = {1'b0, warpOff}  + CMP_W'(l);
    assign descMask[l] = (globalIdx < {1'b0, cfgBound}) &&
                         (localIdx  < CMP_W'(cfgThreads));
  end

  assign descEmpty = ~|descMask;

endmodule

// File: rtl/warp_splitter.sv
module warp_splitter
  import warp_split_pkg::*;
#(
  parameter int WARP_LANES = 32,
  parameter int IDX_W      = 32,
  parameter int BLK_W      = 16,
  parameter int TPB_W      = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  launchValid,
  output logic                  launchReady,
  input  logic [BLK_W-1:0]      gridBlocks,
  input  logic [TPB_W-1:0]      blockThreads,
  input  logic [IDX_W-1:0]      elemCount,
  output logic                  descValid,
  input  logic                  descReady,
  output logic [BLK_W-1:0]      descBlock,
  output logic [TPB_W-1:0]      descWarp,
  output logic [IDX_W-1:0]      descBase,
  output logic [WARP_LANES-1:0] descMask,
  output logic                  descEmpty,
  output logic                  done
);

  ws_strobe_t stb;
  logic       zeroLaunch;
  logic       lastWarp;
  logic       lastBlock;

  assign zeroLaunch = (gridBlocks == '0) || (blockThreads == '0);

  ws_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .launchValid (launchValid),
    .zeroLaunch  (zeroLaunch),
    .descReady   (descReady),
    .lastWarp    (lastWarp),
    .lastBlock   (lastBlock),
    .launchReady (launchReady),
    .descValid   (descValid),
    .done        (done),
    .stb         (stb)
  );

  ws_datapath #(
    .WARP_LANES (WARP_LANES),
    .IDX_W      (IDX_W),
    .BLK_W      (BLK_W),
    .TPB_W      (TPB_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .gridBlocks   (gridBlocks),
    .blockThreads (blockThreads),
    .elemCount    (elemCount),
    .descBlock    (descBlock),
    .descWarp     (descWarp),
    .descBase     (descBase),
    .descMask     (descMask),
    .descEmpty    (descEmpty),
    .lastWarp     (lastWarp),
    .lastBlock    (lastBlock)
  );

endmodule

// File: rtl/warp_splitter_chk.sv
module warp_splitter_chk #(
  parameter int WARP_LANES = 32,
  parameter int IDX_W      = 32,
  parameter int BLK_W      = 16,
  parameter int TPB_W      = 16
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  launchReady,
  input logic                  descValid,
  input logic                  descReady,
  input logic [BLK_W-1:0]      descBlock,
  input logic [TPB_W-1:0]      descWarp,
  input logic [IDX_W-1:0]      descBase,
  input logic [WARP_LANES-1:0] descMask,
  input logic                  done
);

  // R7: a stalled descriptor stays on the outputs unchanged
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    descValid && !descReady |=> descValid && $stable(descBase) &&
      $stable(descMask) && $stable(descBlock) && $stable(descWarp));

  // R5: active lanes always form a contiguous run starting at lane 0
  p_mask_prefix_r5: assert property (@(posedge clk) disable iff (!rstN)
    descValid |-> ((descMask + WARP_LANES'(1)) & descMask) == '0);

  // R9: completion is signalled only once the stream has drained
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> launchReady && !descValid);

  // R10: no launch can be taken while descriptors are pending
  p_busy_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    descValid |-> !launchReady);

  // R3: an accepted descriptor is replaced by a different warp or the run ends
  p_advance_r3: assert property (@(posedge clk) disable iff (!rstN)
    descValid && descReady |=> launchReady ||
      descWarp != $past(descWarp) || descBlock != $past(descBlock));

endmodule

bind warp_splitter warp_splitter_chk #(
  .WARP_LANES (WARP_LANES),
  .IDX_W      (IDX_W),
  .BLK_W      (BLK_W),
  .TPB_W      (TPB_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .launchReady (launchReady),
  .descValid   (descValid),
  .descReady   (descReady),
  .descBlock   (descBlock),
  .descWarp    (descWarp),
  .descBase    (descBase),
  .descMask    (descMask),
  .done        (done)
);

// File: tb/warp_splitter_bench.sv
`timescale 1ns/1ps
module warp_splitter_bench;

  localparam int W  = 32;
  localparam int IW = 32;
  localparam int BW = 16;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          launchValid = 1'b0;
  logic          launchReady;
  logic [BW-1:0] gridBlocks = '0;
  logic [TW-1:0] blockThreads = '0;
  logic [IW-1:0] elemCount = '0;
  logic          descValid;
  logic          descReady = 1'b0;
  logic [BW-1:0] descBlock;
  logic [TW-1:0] descWarp;
  logic [IW-1:0] descBase;
  logic [W-1:0]  descMask;
  logic          descEmpty;
  logic          done;

  always #2.5 clk = ~clk;

  warp_splitter u_warp_splitter (
    .clk (clk), .rstN (rstN),
    .launchValid (launchValid), .launchReady (launchReady),
    .gridBlocks (gridBlocks), .blockThreads (blockThreads), .elemCount (elemCount),
    .descValid (descValid), .descReady (descReady),
    .descBlock (descBlock), .descWarp (descWarp), .descBase (descBase),
    .descMask (descMask), .descEmpty (descEmpty), .done (done)
  );

  typedef struct {
    int          blk;
    int          wrp;
    int          base;
    logic [W-1:0] mask;
  } exp_t;

  exp_t  expQ[$];
  int    tests = 0;
  int    fails = 0;
  int    cyc = 0;
  int    fires = 0;
  int    lastFireCyc = -10;
  string curReq = "R1";
  bit    zeroMode = 1'b0;
  bit    throttle = 1'b0;
  bit    prevStall = 1'b0;
  logic [31:0]  lfsr = 32'hACE1_1234;
  logic [BW-1:0] pBlk;
  logic [TW-1:0] pWrp;
  logic [IW-1:0] pBase;
  logic [W-1:0]  pMask;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ready driver
  initial forever begin
    @(posedge clk);
    #1;
    lfsr      = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    descReady = throttle ? lfsr[0] : 1'b1;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (prevStall) begin
        check(descValid && descBlock == pBlk && descWarp == pWrp &&
              descBase == pBase && descMask == pMask,
              "R7", "stalled descriptor changed", longint'(descBase), longint'(pBase));
      end
      if (descValid && descReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R3", "unexpected descriptor base", longint'(descBase), -1);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check(int'(descBlock) == e.blk && int'(descWarp) == e.wrp,
                curReq, "block/warp (R3)",
                longint'({descBlock, descWarp}), longint'({e.blk[15:0], e.wrp[15:0]}));
          check(int'(descBase) == e.base, curReq, "base (R4)",
                longint'(descBase), longint'(e.base));
          check(descMask == e.mask, curReq, "mask (R5)",
                longint'(descMask), longint'(e.mask));
          check(descEmpty == (e.mask == '0), "R8", "empty flag",
                longint'(descEmpty), longint'(e.mask == '0));
        end
        fires++;
        lastFireCyc = cyc;
      end
      if (done && !zeroMode) begin
        check(lastFireCyc == cyc - 1, "R9", "done not one cycle after final accept",
              longint'(lastFireCyc), longint'(cyc - 1));
      end
      prevStall = descValid && !descReady;
      pBlk = descBlock; pWrp = descWarp; pBase = descBase; pMask = descMask;
    end
  end

  task automatic runLaunch(int g, int t, int n, string req, bit thr);
    int nw;
    nw = (t + W - 1) / W;
    for (int b = 0; b < g; b++) begin
      for (int w = 0; w < nw; w++) begin
        exp_t e;
        e.blk  = b;
        e.wrp  = w;
        e.base = b * t + w * W;
        e.mask = '0;
        for (int l = 0; l < W; l++)
          if (w * W + l < t && e.base + l < n) e.mask[l] = 1'b1;
        expQ.push_back(e);
      end
    end
    curReq   = req;
    throttle = thr;
    fires    = 0;
    @(negedge clk);
    gridBlocks   = BW'(g);
    blockThreads = TW'(t);
    elemCount    = IW'(n);
    launchValid  = 1'b1;
    @(posedge clk);
    #1 launchValid = 1'b0;
    do @(negedge clk); while (!done);
    check(expQ.size() == 0, "R9", "descriptors left at done",
          longint'(expQ.size()), 0);
    expQ.delete();
  endtask

  task automatic zeroLaunch(int g, int t);
    zeroMode = 1'b1;
    fires    = 0;
    @(negedge clk);
    gridBlocks   = BW'(g);
    blockThreads = TW'(t);
    elemCount    = 100;
    launchValid  = 1'b1;
    @(posedge clk);
    #1 launchValid = 1'b0;
    @(negedge clk);
    check(done && !descValid, "R11", "done after zero launch",
          longint'({done, descValid}), 2);
    @(negedge clk);
    check(!done && !descValid && fires == 0, "R11", "zero launch left activity",
          longint'(fires), 0);
    zeroMode = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(!descValid && launchReady && !done, "R1", "reset state",
          longint'({descValid, launchReady, done}), 3'b010);

    // R2: 128-thread block gives four full warps
    runLaunch(1, 128, 128, "R2 R3 R4", 1'b0);
    check(fires == 4, "R2", "warp count for 128 threads", longint'(fires), 4);

    // R6: bound check splits warp 1
    runLaunch(1, 64, 60, "R6 R5", 1'b0);
    check(fires == 2, "R6", "warp count for 64 threads", longint'(fires), 2);

    // small blocks, base strides by block size
    runLaunch(4, 4, 16, "R4 R5", 1'b0);

    // partial last warp plus a bound-empty warp, throttled
    runLaunch(2, 48, 80, "R5 R7 R8", 1'b1);

    // empty warps from small N, throttled
    runLaunch(4, 4, 6, "R8 R7", 1'b1);

    // R11: zero-sized launches
    zeroLaunch(0, 64);
    zeroLaunch(3, 0);

    // R10: launch request while busy is ignored
    fork
      runLaunch(3, 64, 150, "R10 R3", 1'b1);
      begin
        repeat (3) @(negedge clk);
        check(!launchReady, "R10", "launchReady while busy",
              longint'(launchReady), 0);
        gridBlocks   = 7;
        blockThreads = 9;
        elemCount    = 3;
        launchValid  = 1'b1;
        @(negedge clk);
        launchValid  = 1'b0;
      end
    join

    runLaunch(1, 40, 100, "R5 R10", 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule